// File: doc/BRIEF.md
# Group-Predicated Short-Vector Adder

This block adds two vectors of short vectors and writes the sums into a third. A short vector (a "group") holds one to four lanes. Every lane is an integer of 8, 16, 32 or 64 bits. Lanes are packed densely into 64-bit registers of a small internal register file. One predicate bit controls each group as a whole, so a single bit enables or suppresses every lane of that group. The predicate can be inverted, so that groups run where their bit is clear.

A command is a one-cycle `start` pulse. It carries the base register numbers of the destination and the two sources, the group count, the lane count, the lane width, the predicate register number and the invert flag. The sequencer then handles one element per cycle in ascending element order. It reads both source lanes from the register file and writes the wrapped sum back using byte enables. It pulses `done` when it finishes. A host port loads the register file while the block is idle and reads it back at any time.

Top module: `svadd_vec`

## Requirements
- R1: After reset `busy` and `done` are 0 and every register of the file reads back as zero.
- R2: Element e of an operand whose base register is B, with lane width w, lives in register (B + e / (64/w)) mod 32 at bit offset (e mod (64/w))*w. For an enabled group i, each lane k produces element e = i*n + k, where n is the lane count. Its value is rs1 element plus rs2 element, modulo 2^w.
- R3: `lanes_code` values 0, 1, 2 and 3 select a lane count n of 1, 2, 3 and 4.
- R4: `width_code` values 0, 1, 2 and 3 select a lane width w of 8, 16, 32 and 64 bits. Each write enables exactly w/8 bytes.
- R5: Group i (0 ≤ i < 64) is controlled by bit i of the predicate register. With `pred_inv`=0 the group runs when the bit is 1. With `pred_inv`=1 it runs when the bit is 0.
- R6: A suppressed group leaves its destination elements unchanged. Every write also leaves all bytes outside the written element unchanged.
- R7: Elements are processed one per cycle in ascending element order. When the destination overlaps a source, later elements read the values already written by earlier ones.
- R8: `done` is a one-cycle pulse. It is high in the (N+1)-th cycle after the cycle in which `start` is taken, where N = group count × n. A group count of 0 gives `done` in the first cycle after `start`.
- R9: `busy` is high from the cycle after `start` is taken up to and including the `done` cycle. A `start` pulse while busy is ignored.
- R10: Host writes (`host_we`, full 64-bit register) take effect only while idle and are ignored while busy. `host_rdata` shows register `host_raddr` combinationally.
- R11: The predicate register is sampled when `start` is taken. Later writes to it, including writes by the running command, do not change which groups run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse, taken when idle |
| dst_base | input | 5 | Destination base register |
| srca_base | input | 5 | First source base register |
| srcb_base | input | 5 | Second source base register |
| grp_count | input | 7 | Number of groups (0 to 64) |
| lanes_code | input | 2 | Lane count minus one |
| width_code | input | 2 | Lane width select |
| pred_sel | input | 5 | Predicate register number |
| pred_inv | input | 1 | Invert predicate bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| host_we | input | 1 | Host register write |
| host_waddr | input | 5 | Host write register |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host read register |
| host_rdata | output | 64 | Host read data |

## Verification
The checker watches properties on every cycle. It confirms that `done` lasts one cycle and falls inside `busy`, and that `busy` drops only through `done`, so a second `start` cannot cut a run short. It also confirms that the engine writes only while busy, that host writes never reach the file during a run, and that every engine write enables exactly the byte count of the selected width. Whether the sums, element placement, predicate polarity, group suppression, overlap ordering and predicate capture are right can only be shown by the bench's scenarios. The bench compares the whole register file after each command against a sequential model.

// File: rtl/svadd_pkg.sv
package svadd_pkg;
  localparam int XLEN  = 64;
  localparam int NREGS = 32;
  localparam int AW    = $clog2(NREGS);
  localparam int VLW   = 7;
  localparam int EIW   = VLW + 2;
  localparam int NBYTE = XLEN / 8;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_state_e;

  typedef struct packed {
    logic [AW-1:0]  dst;
    logic [AW-1:0]  srca;
    logic [AW-1:0]  srcb;
    logic [VLW-1:0] groups;
    logic [1:0]     lanes;
    logic [1:0]     width;
  } op_cfg_t;

  // log2 of elements per register
  function automatic logic [1:0] per_reg_log(input logic [1:0] wc);
    return 2'(3 - int'(wc));
  endfunction

  function automatic logic [2:0] slot_of(input logic [EIW-1:0] e, input logic [1:0] wc);
    case (wc)
      2'd0:    return e[2:0];
      2'd1:    return {1'b0, e[1:0]};
      2'd2:    return {2'b0, e[0]};
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] width_mask(input logic [1:0] wc);
    case (wc)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [5:0] bit_offset(input logic [2:0] slot, input logic [1:0] wc);
    return 6'({slot, 3'b000}) << wc;
  endfunction

  function automatic logic [XLEN-1:0] lane_get(input logic [XLEN-1:0] word,
                                               input logic [2:0] slot, input logic [1:0] wc);
    return (word >> bit_offset(slot, wc)) & width_mask(wc);
  endfunction

  function automatic logic [XLEN-1:0] lane_sum(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b, input logic [1:0] wc);
    return (a + b) & width_mask(wc);
  endfunction

  function automatic logic [NBYTE-1:0] lane_bytes(input logic [2:0] slot, input logic [1:0] wc);
    logic [NBYTE-1:0] base;
    case (wc)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << (slot << wc);
  endfunction
endpackage

// File: rtl/svadd_rf.sv
module svadd_rf
  import svadd_pkg::*;
#(
  parameter int NR  = NREGS,
  parameter int RAW = AW,
  parameter int NRP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW-1:0]    raddr [NRP],
  output logic [XLEN-1:0]   rdata [NRP],
  input  logic              we,
  input  logic [RAW-1:0]    waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [NBYTE-1:0]  wbe
);
  logic [XLEN-1:0] mem [NR];

  for (genvar r = 0; r < NR; r++) begin : g_reg
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[r][b*8 +: 8] <= '0;
        else if (we && waddr == RAW'(r) && wbe[b])
          mem[r][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/svadd_seq.sv
module svadd_seq
  import svadd_pkg::*;
#(
  parameter int PW = XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_cfg_t         cfg_in,
  input  logic [PW-1:0]   pred_word,
  input  logic            pred_inv,
  output op_cfg_t         cfg,
  output logic [VLW-1:0]  grp,
  output logic [1:0]      lane,
  output logic            step,
  output logic            grp_en,
  output logic            busy,
  output logic            done
);
  localparam int GIW = $clog2(PW);

  seq_state_e      state;
  logic [PW-1:0]   run_mask;
  logic            last;

  assign step   = (state == S_RUN);
  assign done   = (state == S_FIN);
  assign busy   = (state != S_IDLE);
  assign grp_en = run_mask[grp[GIW-1:0]];
  assign last   = step && (lane == cfg.lanes) && (grp == cfg.groups - VLW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg      <= '0;
      grp      <= '0;
      lane     <= '0;
      run_mask <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cfg      <= cfg_in;
          run_mask <= pred_inv ? ~pred_word : pred_word;
          grp      <= '0;
          lane     <= '0;
          state    <= (cfg_in.groups == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (last) begin
            state <= S_FIN;
          end else if (lane == cfg.lanes) begin
            lane <= '0;
            grp  <= grp + VLW'(1);
          end else begin
            lane <= lane + 2'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/svadd_lane.sv
module svadd_lane
  import svadd_pkg::*;
(
  input  op_cfg_t           cfg,
  input  logic [VLW-1:0]    grp,
  input  logic [1:0]        lane,
  input  logic              step,
  input  logic              grp_en,
  input  logic [XLEN-1:0]   srca_word,
  input  logic [XLEN-1:0]   srcb_word,
  output logic [AW-1:0]     srca_addr,
  output logic [AW-1:0]     srcb_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [XLEN-1:0]   wr_data,
  output logic [NBYTE-1:0]  wr_be
);
  logic [EIW-1:0]  eidx;
  logic [EIW-1:0]  roff;
  logic [2:0]      slot;
  logic [XLEN-1:0] sum;

  always_comb begin
    eidx      = EIW'(grp) * EIW'({1'b0, cfg.lanes} + 3'd1) + EIW'(lane);
    roff      = eidx >> per_reg_log(cfg.width);
    slot      = slot_of(eidx, cfg.width);
    srca_addr = cfg.srca + AW'(roff);
    srcb_addr = cfg.srcb + AW'(roff);
    wr_addr   = cfg.dst + AW'(roff);
    sum       = lane_sum(lane_get(srca_word, slot, cfg.width),
                         lane_get(srcb_word, slot, cfg.width), cfg.width);
    wr_data   = sum << bit_offset(slot, cfg.width);
    wr_be     = lane_bytes(slot, cfg.width);
    wr_en     = step && grp_en;
  end
endmodule

// File: rtl/svadd_vec.sv
module svadd_vec
  import svadd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      dst_base,
  input  logic [4:0]      srca_base,
  input  logic [4:0]      srcb_base,
  input  logic [6:0]      grp_count,
  input  logic [1:0]      lanes_code,
  input  logic [1:0]      width_code,
  input  logic [4:0]      pred_sel,
  input  logic            pred_inv,
  output logic            busy,
  output logic            done,
  input  logic            host_we,
  input  logic [4:0]      host_waddr,
  input  logic [63:0]     host_wdata,
  input  logic [4:0]      host_raddr,
  output logic [63:0]     host_rdata
);
  op_cfg_t          cfg_in, cfg;
  logic [VLW-1:0]   grp;
  logic [1:0]       lane;
  logic             step, grp_en;
  logic [AW-1:0]    rf_raddr [4];
  logic [XLEN-1:0]  rf_rdata [4];
  logic [AW-1:0]    srca_addr, srcb_addr, eng_addr;
  logic             eng_we;
  logic [XLEN-1:0]  eng_data;
  logic [NBYTE-1:0] eng_be;
  logic             rf_we;
  logic [AW-1:0]    rf_waddr;
  logic [XLEN-1:0]  rf_wdata;
  logic [NBYTE-1:0] rf_wbe;

  assign cfg_in = '{dst: dst_base, srca: srca_base, srcb: srcb_base,
                    groups: grp_count, lanes: lanes_code, width: width_code};

  svadd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .pred_word(rf_rdata[0]), .pred_inv(pred_inv), .cfg(cfg),
    .grp(grp), .lane(lane), .step(step), .grp_en(grp_en),
    .busy(busy), .done(done)
  );

  svadd_lane u_lane (
    .cfg(cfg), .grp(grp), .lane(lane), .step(step), .grp_en(grp_en),
    .srca_word(rf_rdata[1]), .srcb_word(rf_rdata[2]),
    .srca_addr(srca_addr), .srcb_addr(srcb_addr),
    .wr_en(eng_we), .wr_addr(eng_addr), .wr_data(eng_data), .wr_be(eng_be)
  );

  assign rf_raddr[0] = pred_sel;
  assign rf_raddr[1] = srca_addr;
  assign rf_raddr[2] = srcb_addr;
  assign rf_raddr[3] = host_raddr;
  assign host_rdata  = rf_rdata[3];

  always_comb begin
    if (busy) begin
      rf_we = eng_we;  rf_waddr = eng_addr;   rf_wdata = eng_data;   rf_wbe = eng_be;
    end else begin
      rf_we = host_we; rf_waddr = host_waddr; rf_wdata = host_wdata; rf_wbe = '1;
    end
  end

  svadd_rf u_rf (
    .clk(clk), .rst_n(rst_n), .raddr(rf_raddr), .rdata(rf_rdata),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata), .wbe(rf_wbe)
  );
endmodule

// File: rtl/svadd_chk.sv
module svadd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       eng_we,
  input logic [7:0] eng_be,
  input logic [1:0] ew,
  input logic       rf_we
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_busy_ends_by_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r10_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_we) |-> !rf_we);
  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> busy);
  a_r4_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> ($countones(eng_be) == (1 << ew)));
endmodule

bind svadd_vec svadd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .eng_we(eng_we),
  .eng_be(eng_be), .ew(cfg.width), .rf_we(rf_we)
);

// File: tb/test_svadd_vec.sv
`timescale 1ns/1ps
module test_svadd_vec;
  logic clk = 0, rst_n = 0, start = 0, pred_inv = 0, host_we = 0;
  logic [4:0] dst_base = 0, srca_base = 0, srcb_base = 0, pred_sel = 0;
  logic [4:0] host_waddr = 0, host_raddr = 0;
  logic [6:0] grp_count = 0;
  logic [1:0] lanes_code = 0, width_code = 0;
  logic [63:0] host_wdata = 0, host_rdata;
  logic busy, done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] m [32];

  always #2.5 clk = ~clk;

  svadd_vec i_svadd_vec (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench restatement of element placement
  function automatic int unsigned regno(input int base, input int e, input int w);
    return (base + e / (64 / w)) % 32;
  endfunction
  function automatic logic [63:0] eget(input int base, input int e, input int w);
    logic [63:0] v = m[regno(base, e, w)] >> ((e % (64 / w)) * w);
    return (w == 64) ? v : (v & ((64'd1 << w) - 1));
  endfunction
  task automatic eput(input int base, input int e, input int w, input logic [63:0] v);
    int unsigned r = regno(base, e, w);
    int sh = (e % (64 / w)) * w;
    logic [63:0] msk = (w == 64) ? '1 : (((64'd1 << w) - 1) << sh);
    m[r] = (m[r] & ~msk) | ((v << sh) & msk);
  endtask

  task automatic hwrite(input int r, input logic [63:0] v);
    @(negedge clk);
    host_we = 1; host_waddr = 5'(r); host_wdata = v;
    @(negedge clk);
    host_we = 0;
    m[r] = v;
  endtask

  task automatic fill_random();
    for (int r = 0; r < 32; r++) hwrite(r, {$urandom, $urandom});
  endtask

  task automatic compare_all(input string req);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      host_raddr = 5'(r);
      #1;
      chk(host_rdata === m[r], req, host_rdata, m[r]);
    end
  endtask

  // poke: during the run, pulse start and a host write to register 'pokereg'
  task automatic run_op(input int d, input int a, input int b, input int g, input int lc,
                        input int wc, input int ps, input bit inv, input bit poke,
                        input int pokereg, input string req);
    int w = 8 << wc;
    int n = lc + 1;
    int total = g * n;
    logic [63:0] pm = inv ? ~m[ps] : m[ps];
    int k;
    bit seen_done = 0;
    for (int i = 0; i < g; i++)
      if (pm[i])
        for (int l = 0; l < n; l++)
          eput(d, i * n + l, w, (eget(a, i * n + l, w) + eget(b, i * n + l, w)));
    @(negedge clk);
    start = 1; dst_base = 5'(d); srca_base = 5'(a); srcb_base = 5'(b);
    grp_count = 7'(g); lanes_code = 2'(lc); width_code = 2'(wc);
    pred_sel = 5'(ps); pred_inv = inv;
    @(negedge clk);
    start = 0;
    k = 1;
    chk(busy === 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    while (!seen_done && k < 400) begin
      if (poke && k == 1) begin
        start = 1; grp_count = 7'd3; dst_base = 5'(pokereg); lanes_code = 2'd0;
        host_we = 1; host_waddr = 5'(pokereg); host_wdata = ~m[pokereg];
      end else begin
        start = 0; host_we = 0;
      end
      if (done) begin
        seen_done = 1;
        chk(k == total + 1, {req, " R8 done timing"}, 64'(k), 64'(total + 1));
      end else begin
        k++;
        @(negedge clk);
      end
    end
    start = 0; host_we = 0;
    if (!seen_done) chk(0, {req, " R8 no done"}, 64'(k), 64'(total + 1));
    @(negedge clk);
    chk(!busy && !done, {req, " R9 idle after done"}, {62'd0, busy, done}, 64'd0);
    compare_all(req);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {62'd0, busy, done}, 64'd0);
    for (int r = 0; r < 32; r++) m[r] = '0;
    compare_all("R1 reset regfile");

    fill_random();
    // short-vector add of 16-bit lanes, inverted predicate
    run_op(8, 12, 16, 5, 2, 1, 9, 1, 0, 0, "R2 R5 inverted ew16 n3");
    hwrite(9, 64'h0000_0000_0000_0015);
    run_op(8, 12, 16, 5, 2, 1, 9, 0, 0, 0, "R5 R6 plain predicate");
    hwrite(3, '1);
    run_op(20, 4, 12, 7, 0, 2, 3, 0, 0, 0, "R3 one lane ew32");
    run_op(0, 10, 14, 16, 3, 0, 3, 0, 0, 0, "R3 R4 four lanes ew8");
    run_op(16, 2, 6, 3, 1, 3, 3, 0, 0, 0, "R4 ew64 two lanes");
    run_op(5, 6, 7, 0, 3, 1, 3, 0, 0, 0, "R8 zero groups");
    for (int r = 10; r < 14; r++) hwrite(r, '1);
    for (int r = 14; r < 18; r++) hwrite(r, 64'h0001_0001_0001_0001);
    run_op(20, 10, 14, 8, 1, 1, 3, 0, 0, 0, "R2 wrap modulo");
    run_op(30, 1, 9, 2, 3, 3, 3, 0, 0, 0, "R2 register wrap");
    fill_random();
    run_op(4, 4, 5, 12, 2, 0, 3, 0, 0, 0, "R7 overlap dst src");
    run_op(7, 12, 20, 8, 3, 3, 8, 0, 0, 0, "R11 predicate overwritten");
    run_op(4, 12, 20, 6, 1, 1, 0, 0, 1, 28, "R9 R10 start and host write ignored");
    hwrite(2, 64'h0);
    run_op(9, 12, 20, 5, 3, 2, 2, 0, 0, 0, "R5 all suppressed");

    for (int t = 0; t < 25; t++) begin
      int g = $urandom_range(0, 20);
      if (t % 5 == 0) fill_random();
      if (t == 7) g = 64;
      run_op($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), g,
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 31),
             1'($urandom_range(0, 1)), 0, 0, "R2 R5 random");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule